// File: doc/BRIEF.md
# Serial Page-Buffered Memory Programmer

This block receives programming instructions one byte at a time from a byte-serial front end. Each instruction is four bytes long, and the block carries it out against two small memory models built from registers: a program memory of 16-bit words and a byte-wide EEPROM. Load instructions never write to a memory. They place data into a page buffer at an offset taken from the low address bits. A page-write instruction then copies the whole buffer into one memory page, which the upper address bits select, and erases the buffer.

Each accepted byte is answered one cycle later with a returned byte. After a page write the block reports busy for a configurable number of cycles. Any byte that arrives while busy is dropped.

Top module: `pageProgrammer`

## Requirements
- R1: An instruction is four accepted bytes. Byte 1 is the opcode, byte 2 is address bits 15:8, byte 3 is address bits 7:0, and byte 4 is the data. Nothing acts before byte 4.
- R2: Every accepted byte raises respValid for one cycle on the next clock. respByte is 0x00 for byte 1. For bytes 2 to 4 it is the previous byte of the same instruction, so byte 4 returns byte 3.
- R3: Opcode 0x40 writes the data into bits 7:0 of program-buffer word address[1:0]. No memory changes.
- R4: Opcode 0x48 writes the data into bits 15:8 of program-buffer word address[1:0]. No memory changes.
- R5: Opcode 0x4C copies the program buffer into program page address>>2 when that page exists, and leaves other pages unchanged. It always resets every buffer word to 0xFFFF. Word w of page p sits at progMem bits [(p*PAGE_WORDS+w)*16 +: 16].
- R6: Opcode 0xC1 writes the data into EEPROM-buffer byte address[1:0]. Opcode 0xC2 copies that buffer into EEPROM page address>>2 when the page exists, then resets the buffer to 0xFF. Byte b of page p sits at eeMem bits [(p*EE_PAGE_BYTES+b)*8 +: 8].
- R7: busy is high for exactly WRITE_CYCLES cycles, starting the cycle after byte 4 of a page write. A byte arriving while busy gets no response and does not advance the framing.
- R8: An instruction with any other opcode changes no memory and no buffer.
- R9: After reset, both memories and both buffers read as all ones, busy and respValid are low, and the next byte is byte 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| byteValid | input | 1 | Instruction byte strobe |
| byteIn | input | 8 | Instruction byte |
| respValid | output | 1 | Returned byte valid |
| respByte | output | 8 | Returned byte |
| busy | output | 1 | Page write in progress |
| progMem | output | PROG_PAGES*PAGE_WORDS*16 | Program memory contents |
| eeMem | output | EE_PAGES*EE_PAGE_BYTES*8 | EEPROM contents |

## Verification
The bench writes the same word offset with separate low and high loads. A design that merged the two loads, or swapped their halves, would leave the wrong word in the committed page. It commits twice without reloading, so a buffer that is never erased would copy stale data into the second page. It also targets page numbers beyond the memory, where an address that wraps would overwrite a real page. Bytes sent during busy check that a design which accepts them or counts them shifts the framing of every later instruction, and the exact busy length is counted cycle by cycle.

// File: rtl/pageProgPkg.sv
package pageProgPkg;
  localparam logic [7:0] OP_LOAD_LO    = 8'h40;
  localparam logic [7:0] OP_LOAD_HI    = 8'h48;
  localparam logic [7:0] OP_WRITE_PAGE = 8'h4C;
  localparam logic [7:0] OP_EE_LOAD    = 8'hC1;
  localparam logic [7:0] OP_EE_WRITE   = 8'hC2;

  // strobes from the control to the datapath, valid in the byte-4 cycle
  typedef struct packed {
    logic        loadLo;
    logic        loadHi;
    logic        progCommit;
    logic        eeLoad;
    logic        eeCommit;
    logic [15:0] addr;
    logic [7:0]  data;
  } progStrobe_t;
endpackage

// File: rtl/pageProgCtrl.sv
module pageProgCtrl
  import pageProgPkg::*;
#(
  parameter int WRITE_CYCLES = 6
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        byteValid,
  input  logic [7:0]  byteIn,
  output logic        respValid,
  output logic [7:0]  respByte,
  output logic        busy,
  output progStrobe_t strobe
);
  localparam int CW = $clog2(WRITE_CYCLES + 1);

  logic [1:0]    bytePos;
  logic [7:0]    opReg;
  logic [7:0]    addrHiReg;
  logic [7:0]    prevByte;
  logic [CW-1:0] busyCnt;
  logic          accept;
  logic          lastByte;

  assign busy     = (busyCnt != '0);
  assign accept   = byteValid && !busy;
  assign lastByte = accept && (bytePos == 2'd3);

  always_comb begin
    strobe      = '0;
    strobe.addr = {addrHiReg, prevByte};
    strobe.data = byteIn;
    if (lastByte) begin
      unique case (opReg)
        OP_LOAD_LO:    strobe.loadLo     = 1'b1;
        OP_LOAD_HI:    strobe.loadHi     = 1'b1;
        OP_WRITE_PAGE: strobe.progCommit = 1'b1;
        OP_EE_LOAD:    strobe.eeLoad     = 1'b1;
        OP_EE_WRITE:   strobe.eeCommit   = 1'b1;
        default:       ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bytePos   <= '0;
      opReg     <= '0;
      addrHiReg <= '0;
      prevByte  <= '0;
      respValid <= 1'b0;
      respByte  <= '0;
      busyCnt   <= '0;
    end else begin
      respValid <= accept;
      if (accept) begin
        bytePos  <= bytePos + 2'd1;
        prevByte <= byteIn;
        respByte <= (bytePos == 2'd0) ? 8'h00 : prevByte;
        if (bytePos == 2'd0) opReg     <= byteIn;
        if (bytePos == 2'd1) addrHiReg <= byteIn;
      end
      if (strobe.progCommit || strobe.eeCommit)
        busyCnt <= CW'(WRITE_CYCLES);
      else if (busy)
        busyCnt <= busyCnt - 1'b1;
    end
  end

  AST_RESP_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    byteValid && !busy |=> respValid);                                           // R2
  AST_DROP_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    byteValid && busy |=> !respValid);                                           // R7
  AST_COMMIT_SETS_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.progCommit || strobe.eeCommit) |=> busy);                            // R7
  AST_NO_ACTION_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !(strobe.loadLo || strobe.loadHi || strobe.progCommit || strobe.eeLoad || strobe.eeCommit)); // R7
  AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.loadLo, strobe.loadHi, strobe.progCommit, strobe.eeLoad, strobe.eeCommit})); // R1
endmodule

// File: rtl/pageProgData.sv
module pageProgData
  import pageProgPkg::*;
#(
  parameter int PROG_PAGES    = 4,
  parameter int PAGE_WORDS    = 4,
  parameter int EE_PAGES      = 4,
  parameter int EE_PAGE_BYTES = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  progStrobe_t strobe,
  output logic [PROG_PAGES*PAGE_WORDS*16-1:0] progMem,
  output logic [EE_PAGES*EE_PAGE_BYTES*8-1:0] eeMem
);
  localparam int OFFW  = $clog2(PAGE_WORDS);
  localparam int EOFFW = $clog2(EE_PAGE_BYTES);

  logic [15:0] progBuf [PAGE_WORDS];
  logic [7:0]  eeBuf   [EE_PAGE_BYTES];
  logic [15:0] progArr [PROG_PAGES][PAGE_WORDS];
  logic [7:0]  eeArr   [EE_PAGES][EE_PAGE_BYTES];

  logic [OFFW-1:0]  progOff;
  logic [EOFFW-1:0] eeOff;
  logic [15:0]      progPage;
  logic [15:0]      eePage;
  logic             progPageOk;
  logic             eePageOk;

  assign progOff    = strobe.addr[OFFW-1:0];
  assign eeOff      = strobe.addr[EOFFW-1:0];
  assign progPage   = strobe.addr >> OFFW;
  assign eePage     = strobe.addr >> EOFFW;
  assign progPageOk = (32'(progPage) < PROG_PAGES);
  assign eePageOk   = (32'(eePage) < EE_PAGES);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int w = 0; w < PAGE_WORDS; w++) progBuf[w] <= 16'hFFFF;
      for (int b = 0; b < EE_PAGE_BYTES; b++) eeBuf[b] <= 8'hFF;
      for (int p = 0; p < PROG_PAGES; p++)
        for (int w = 0; w < PAGE_WORDS; w++) progArr[p][w] <= 16'hFFFF;
      for (int p = 0; p < EE_PAGES; p++)
        for (int b = 0; b < EE_PAGE_BYTES; b++) eeArr[p][b] <= 8'hFF;
    end else begin
      if (strobe.loadLo) progBuf[progOff][7:0]  <= strobe.data;
      if (strobe.loadHi) progBuf[progOff][15:8] <= strobe.data;
      if (strobe.eeLoad) eeBuf[eeOff]           <= strobe.data;
      if (strobe.progCommit) begin
        for (int w = 0; w < PAGE_WORDS; w++) begin
          if (progPageOk) progArr[progPage[$clog2(PROG_PAGES+1)-1:0]][w] <= progBuf[w];
          progBuf[w] <= 16'hFFFF;
        end
      end
      if (strobe.eeCommit) begin
        for (int b = 0; b < EE_PAGE_BYTES; b++) begin
          if (eePageOk) eeArr[eePage[$clog2(EE_PAGES+1)-1:0]][b] <= eeBuf[b];
          eeBuf[b] <= 8'hFF;
        end
      end
    end
  end

  for (genvar p = 0; p < PROG_PAGES; p++) begin : gProgPage
    for (genvar w = 0; w < PAGE_WORDS; w++) begin : gProgWord
      assign progMem[(p*PAGE_WORDS+w)*16 +: 16] = progArr[p][w];
    end
  end
  for (genvar p = 0; p < EE_PAGES; p++) begin : gEePage
    for (genvar b = 0; b < EE_PAGE_BYTES; b++) begin : gEeByte
      assign eeMem[(p*EE_PAGE_BYTES+b)*8 +: 8] = eeArr[p][b];
    end
  end

  AST_PROG_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.progCommit |=> $stable(progMem));                                    // R3
  AST_EE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.eeCommit |=> $stable(eeMem));                                        // R6
  AST_BAD_PAGE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    strobe.progCommit && !progPageOk |=> $stable(progMem));                      // R5
endmodule

// File: rtl/pageProgrammer.sv
module pageProgrammer
  import pageProgPkg::*;
#(
  parameter int PROG_PAGES    = 4,
  parameter int PAGE_WORDS    = 4,
  parameter int EE_PAGES      = 4,
  parameter int EE_PAGE_BYTES = 4,
  parameter int WRITE_CYCLES  = 6
) (
  input  logic clk,
  input  logic rstN,
  input  logic byteValid,
  input  logic [7:0] byteIn,
  output logic respValid,
  output logic [7:0] respByte,
  output logic busy,
  output logic [PROG_PAGES*PAGE_WORDS*16-1:0] progMem,
  output logic [EE_PAGES*EE_PAGE_BYTES*8-1:0] eeMem
);
  progStrobe_t strobe;

  pageProgCtrl #(.WRITE_CYCLES(WRITE_CYCLES)) uCtrl (
    .clk(clk), .rstN(rstN), .byteValid(byteValid), .byteIn(byteIn),
    .respValid(respValid), .respByte(respByte), .busy(busy), .strobe(strobe)
  );

  pageProgData #(
    .PROG_PAGES(PROG_PAGES), .PAGE_WORDS(PAGE_WORDS),
    .EE_PAGES(EE_PAGES), .EE_PAGE_BYTES(EE_PAGE_BYTES)
  ) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .progMem(progMem), .eeMem(eeMem)
  );
endmodule

// File: tb/tb_pageProgrammer.sv
`timescale 1ns/1ps
module tb_pageProgrammer;
  localparam int PP = 4, PW = 4, EP = 4, EB = 4, WC = 6;

  logic clk = 0, rstN = 0, byteValid = 0;
  logic [7:0] byteIn = 0;
  logic respValid, busy;
  logic [7:0] respByte;
  logic [PP*PW*16-1:0] progMem;
  logic [EP*EB*8-1:0] eeMem;

  int checks = 0, fails = 0, cycles = 0;
  logic [15:0] progM [PP][PW];
  logic [15:0] progB [PW];
  logic [7:0]  eeM [EP][EB];
  logic [7:0]  eeB [EB];

  pageProgrammer #(.PROG_PAGES(PP), .PAGE_WORDS(PW), .EE_PAGES(EP),
                   .EE_PAGE_BYTES(EB), .WRITE_CYCLES(WC)) dut (
    .clk(clk), .rstN(rstN), .byteValid(byteValid), .byteIn(byteIn),
    .respValid(respValid), .respByte(respByte), .busy(busy),
    .progMem(progMem), .eeMem(eeMem));

  always #2.5 clk = ~clk;

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles == 150000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d cycles, expected fewer", cycles);
      summary();
      $finish;
    end
  end

  task automatic check(string req, logic [255:0] act, logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [PP*PW*16-1:0] progExp();
    logic [PP*PW*16-1:0] v;
    for (int p = 0; p < PP; p++)
      for (int w = 0; w < PW; w++) v[(p*PW+w)*16 +: 16] = progM[p][w];
    return v;
  endfunction

  function automatic logic [EP*EB*8-1:0] eeExp();
    logic [EP*EB*8-1:0] v;
    for (int p = 0; p < EP; p++)
      for (int b = 0; b < EB; b++) v[(p*EB+b)*8 +: 8] = eeM[p][b];
    return v;
  endfunction

  task automatic sendByte(logic [7:0] b, logic [7:0] expResp);
    @(negedge clk); byteValid = 1; byteIn = b;
    @(negedge clk); byteValid = 0;
    check("R2 respValid", 256'(respValid), 256'(1));
    check("R2 respByte", 256'(respByte), 256'(expResp));
  endtask

  task automatic applyModel(logic [7:0] op, logic [15:0] a, logic [7:0] d);
    int pg;
    case (op)
      8'h40: progB[a[1:0]][7:0]  = d;
      8'h48: progB[a[1:0]][15:8] = d;
      8'hC1: eeB[a[1:0]] = d;
      8'h4C: begin
        pg = int'(a >> 2);
        for (int w = 0; w < PW; w++) begin
          if (pg < PP) progM[pg][w] = progB[w];
          progB[w] = 16'hFFFF;
        end
      end
      8'hC2: begin
        pg = int'(a >> 2);
        for (int b = 0; b < EB; b++) begin
          if (pg < EP) eeM[pg][b] = eeB[b];
          eeB[b] = 8'hFF;
        end
      end
      default: ;
    endcase
  endtask

  task automatic instr(logic [7:0] op, logic [15:0] a, logic [7:0] d, string req);
    int n;
    while (busy) @(negedge clk);
    sendByte(op, 8'h00);
    sendByte(a[15:8], op);
    sendByte(a[7:0], a[15:8]);
    sendByte(d, a[7:0]);
    applyModel(op, a, d);
    check({req, " progMem"}, 256'(progMem), 256'(progExp()));
    check({req, " eeMem"}, 256'(eeMem), 256'(eeExp()));
    if (op == 8'h4C || op == 8'hC2) begin
      n = 0;
      while (busy && n < 100) begin n++; @(negedge clk); end
      check("R7 busy length", 256'(n), 256'(WC));
    end
  endtask

  initial begin
    logic [7:0] ops [5];
    ops[0] = 8'h40; ops[1] = 8'h48; ops[2] = 8'h4C; ops[3] = 8'hC1; ops[4] = 8'hC2;
    for (int p = 0; p < PP; p++) for (int w = 0; w < PW; w++) progM[p][w] = 16'hFFFF;
    for (int w = 0; w < PW; w++) progB[w] = 16'hFFFF;
    for (int p = 0; p < EP; p++) for (int b = 0; b < EB; b++) eeM[p][b] = 8'hFF;
    for (int b = 0; b < EB; b++) eeB[b] = 8'hFF;
    void'($urandom(32'h5eed1));
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R9 reset state
    check("R9 busy", 256'(busy), 256'(0));
    check("R9 respValid", 256'(respValid), 256'(0));
    check("R9 progMem", 256'(progMem), 256'(progExp()));
    check("R9 eeMem", 256'(eeMem), 256'(eeExp()));
    // R3 R4: split loads of one word, then commit (R5)
    instr(8'h40, 16'h0009, 8'h34, "R3");
    instr(8'h48, 16'h0009, 8'h12, "R4");
    instr(8'h40, 16'h0002, 8'hA5, "R3");
    instr(8'h4C, 16'h0008, 8'h00, "R5");
    check("R5 word", 256'(progMem[(2*PW+1)*16 +: 16]), 256'(16'h1234));
    // R5 erased buffer: second commit copies all ones
    instr(8'h4C, 16'h0004, 8'h00, "R5 erase");
    check("R5 erased page", 256'(progMem[1*PW*16 +: PW*16]), {192'd0, {64{1'b1}}});
    // R5 out-of-range page
    instr(8'h40, 16'h0000, 8'h77, "R3");
    instr(8'h4C, 16'h0040, 8'h00, "R5 out of range");
    // R6 EEPROM
    instr(8'hC1, 16'h000E, 8'h5A, "R6");
    instr(8'hC2, 16'h000C, 8'h00, "R6");
    check("R6 byte", 256'(eeMem[(3*EB+2)*8 +: 8]), 256'(8'h5A));
    // R8 unknown opcode
    instr(8'h41, 16'h0001, 8'h99, "R8");
    instr(8'h4C, 16'h0000, 8'h00, "R8 after unknown");
    // R7 bytes during busy are dropped and do not advance framing
    while (busy) @(negedge clk);
    sendByte(8'hC2, 8'h00); sendByte(8'h00, 8'hC2); sendByte(8'h04, 8'h00);
    @(negedge clk); byteValid = 1; byteIn = 8'h00;
    @(negedge clk); byteValid = 0; applyModel(8'hC2, 16'h0004, 8'h00);
    @(negedge clk); byteValid = 1; byteIn = 8'h48;
    @(negedge clk); byteValid = 0;
    check("R7 dropped byte", 256'(respValid), 256'(0));
    instr(8'h48, 16'h0003, 8'hBE, "R1 framing after drop");
    // random traffic
    for (int i = 0; i < 160; i++) begin
      logic [7:0] op;
      logic [15:0] a;
      int k;
      k = int'($urandom % 6);
      op = (k < 5) ? ops[k] : 8'($urandom % 8'h30);
      a = ($urandom % 8 == 0) ? 16'($urandom) : 16'($urandom % 32);
      instr(op, a, 8'($urandom), "R1 random");
    end
    summary();
    $finish;
  end
endmodule